// File: doc/BRIEF.md
# Banked Memory Protection Unit

This block sits between a processor's 16-bit address bus and the memory and device enables of a banked multitasking system. A kernel-owned register holds the bank that the running process executes from. Every bus access is steered to that physical bank. The bank byte that the processor drives is thrown away, so a process cannot address memory that belongs to another process.

The top quarter of the address space, from `$C000` upward, is a common area. It holds shared RAM and the I/O devices, and it maps to the same physical storage whatever bank is current. A second register names one bank as privileged. Any valid access to the common area from a bank other than the privileged one pulls the active-low abort low in the same cycle, and the write strobe for that cycle is held off. The kernel can change both bank registers only while it runs from the privileged bank. A write attempted from any other bank is dropped and also aborts. On every abort the block records the faulting address, the bank and the read/write flag, and the kernel can read them back.

Top module: `bank_guard`

## Requirements
- R1: After reset the current bank and the privileged bank both read 0, abort_n is high and the fault record is zero.
- R2: When addr_valid is high, cpu_addr[15] and cpu_addr[14] are both 1, and the current bank differs from the privileged bank, abort_n is low in that same cycle.
- R3: While the current bank equals the privileged bank, abort_n stays high for every access and every register write.
- R4: An access with cpu_addr below `$C000` never aborts. This includes the boundary addresses `$BFFF`, `$8000` and `$4000`.
- R5: abort_n can go low only in a cycle where addr_valid or reg_we is high.
- R6: phys_bank always equals the current bank register, and cpu_bank has no effect on any output.
- R7: common_sel is high exactly when addr_valid is high and cpu_addr is `$C000` or above.
- R8: A reg_we pulse from the privileged bank loads reg_wdata into the current bank when reg_sel = 0, and into the privileged bank when reg_sel = 1, at the next clock edge. Other reg_sel codes change nothing.
- R9: A reg_we pulse while the current bank is not the privileged bank changes neither bank register and drives abort_n low in that cycle.
- R10: In a cycle with abort_n low, cpu_addr, the current bank and cpu_rw are captured at the clock edge. They read back as reg_sel 2 (address bits 7:0), 3 (address bits 15:8), 4 (bank) and 5 (bit 0 = rw).
- R11: mem_we_n is low exactly when addr_valid is high, cpu_rw is 0 (write) and abort_n is high.
- R12: reg_rdata returns the current bank for reg_sel 0, the privileged bank for 1, the fault fields for 2 to 5, and 0 for 6 and 7, all combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_bank | input | 8 | Bank byte from the processor (discarded) |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| addr_valid | input | 1 | Address on the bus is valid this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for writes and readback |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register readback |
| phys_bank | output | 8 | Physical bank for the access |
| common_sel | output | 1 | Access targets the common area |
| abort_n | output | 1 | Active-low abort request |
| mem_we_n | output | 1 | Active-low memory write enable |

## Verification
The assertions check on every cycle that a common-area access from an unprivileged bank aborts and that a privileged bank never aborts. They also check that abort appears only with a strobe, that an aborted cycle never writes, that a refused register write leaves both banks unchanged, that the fault record follows the aborted access, and that activity on the processor bank byte alone never moves phys_bank. The bench scenarios are needed to show the parts that depend on order: losing privilege by rewriting a bank register, the exact boundary at `$BFFF` and `$C000`, and readback of every fault field after a sequence of aborts. These are compared cycle by cycle against a behavioural model.

// File: rtl/bg_pkg.sv
package bg_pkg;
    typedef enum logic [2:0] {
        SEL_CUR    = 3'd0,
        SEL_PRIV   = 3'd1,
        SEL_FA_LO  = 3'd2,
        SEL_FA_HI  = 3'd3,
        SEL_FBANK  = 3'd4,
        SEL_FRW    = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/bg_region_decode.sv
module bg_region_decode #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    output logic              in_common
);
    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    always_comb begin
        in_common = valid & addr[TOP] & addr[NXT];
    end
endmodule

// File: rtl/bg_bank_regs.sv
module bg_bank_regs #(
    parameter int BANK_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BANK_W-1:0] cur_bank,
    output logic [BANK_W-1:0] priv_bank,
    output logic              is_priv,
    output logic              wr_fault
);
    import bg_pkg::*;

    typedef struct packed {
        logic [BANK_W-1:0] cur;
        logic [BANK_W-1:0] priv;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        is_priv  = (st_q.cur == st_q.priv);
        wr_fault = wr_en & ~is_priv;
        if (wr_en && is_priv) begin
            if (wr_sel == SEL_CUR)  st_d.cur  = wr_data[BANK_W-1:0];
            if (wr_sel == SEL_PRIV) st_d.priv = wr_data[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_bank  = st_q.cur;
    assign priv_bank = st_q.priv;

    p_refused_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (cur_bank != priv_bank)) |=>
            (cur_bank == $past(cur_bank)) && (priv_bank == $past(priv_bank)));
endmodule

// File: rtl/bg_fault_log.sv
module bg_fault_log #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  logic              rw,
    output logic [ADDR_W-1:0] f_addr,
    output logic [BANK_W-1:0] f_bank,
    output logic              f_rw
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic              rw;
    } fault_t;

    fault_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (capture) begin
            rec_d.addr = addr;
            rec_d.bank = bank;
            rec_d.rw   = rw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign f_addr = rec_q.addr;
    assign f_bank = rec_q.bank;
    assign f_rw   = rec_q.rw;

    p_idle_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(f_addr) && $stable(f_bank) && $stable(f_rw));
endmodule

// File: rtl/bank_guard.sv
module bank_guard #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BANK_W-1:0] cpu_bank,
    input  logic              cpu_rw,
    input  logic              addr_valid,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [BANK_W-1:0] phys_bank,
    output logic              common_sel,
    output logic              abort_n,
    output logic              mem_we_n
);
    import bg_pkg::*;

    localparam int HI_W = ADDR_W - DATA_W;

    logic              in_common;
    logic [BANK_W-1:0] cur_bank, priv_bank;
    logic              is_priv, wr_fault, abort;
    logic [ADDR_W-1:0] f_addr;
    logic [BANK_W-1:0] f_bank;
    logic              f_rw;

    bg_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(cpu_addr), .valid(addr_valid), .in_common(in_common)
    );

    bg_bank_regs #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_sel(reg_sel),
        .wr_data(reg_wdata), .cur_bank(cur_bank), .priv_bank(priv_bank),
        .is_priv(is_priv), .wr_fault(wr_fault)
    );

    bg_fault_log #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_log (
        .clk(clk), .rst_n(rst_n), .capture(abort), .addr(cpu_addr),
        .bank(cur_bank), .rw(cpu_rw), .f_addr(f_addr), .f_bank(f_bank),
        .f_rw(f_rw)
    );

    always_comb begin
        abort      = (in_common & ~is_priv) | wr_fault;
        abort_n    = ~abort;
        common_sel = in_common;
        phys_bank  = cur_bank;
        mem_we_n   = ~(addr_valid & ~cpu_rw & ~abort);
        case (reg_sel)
            SEL_CUR:   reg_rdata = DATA_W'(cur_bank);
            SEL_PRIV:  reg_rdata = DATA_W'(priv_bank);
            SEL_FA_LO: reg_rdata = f_addr[DATA_W-1:0];
            SEL_FA_HI: reg_rdata = DATA_W'(f_addr[ADDR_W-1 -: HI_W]);
            SEL_FBANK: reg_rdata = DATA_W'(f_bank);
            SEL_FRW:   reg_rdata = DATA_W'(f_rw);
            default:   reg_rdata = '0;
        endcase
    end

    p_user_top_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && cpu_addr[ADDR_W-1] && cpu_addr[ADDR_W-2] &&
         (cur_bank != priv_bank)) |-> !abort_n);

    p_priv_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank == priv_bank) |-> abort_n);

    p_strobe_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && !reg_we) |-> abort_n);

    p_bank_byte_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cpu_bank) && !$past(reg_we)) |-> $stable(phys_bank));

    p_no_write_on_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n |-> mem_we_n);

    p_fault_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n |=> (f_addr == $past(cpu_addr)) && (f_rw == $past(cpu_rw)));
endmodule

// File: tb/sim_bank_guard.sv
module sim_bank_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_bank = '0;
    logic        cpu_rw = 1'b1;
    logic        addr_valid = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata, phys_bank;
    logic        common_sel, abort_n, mem_we_n;

    int n_chk = 0, n_bad = 0, n_cyc = 0;

    // behavioural reference state
    int m_cur, m_priv, m_faddr, m_fbank, m_frw;

    always #4 clk = ~clk;

    bank_guard u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_bank(cpu_bank),
        .cpu_rw(cpu_rw), .addr_valid(addr_valid), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .phys_bank(phys_bank), .common_sel(common_sel), .abort_n(abort_n),
        .mem_we_n(mem_we_n)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", n_cyc);
            finish_run();
        end
    end

    function automatic int exp_rdata(int sel);
        case (sel)
            0: return m_cur;
            1: return m_priv;
            2: return m_faddr & 255;
            3: return (m_faddr >> 8) & 255;
            4: return m_fbank;
            5: return m_frw;
            default: return 0;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        addr_valid = 1'b0;
        reg_we = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        m_cur = 0; m_priv = 0; m_faddr = 0; m_fbank = 0; m_frw = 0;
    endtask

    // one bus cycle: drive, compare at negedge, advance model at posedge
    task automatic cyc(int addr, int bank, int rw, int valid, int we,
                       int sel, int wd, string req);
        int ab, prot;
        cpu_addr = 16'(addr); cpu_bank = 8'(bank); cpu_rw = rw[0];
        addr_valid = valid[0]; reg_we = we[0]; reg_sel = 3'(sel);
        reg_wdata = 8'(wd);
        @(negedge clk);
        prot = (valid != 0 && addr >= 'hC000) ? 1 : 0;
        ab   = ((prot != 0 || we != 0) && m_cur != m_priv) ? 1 : 0;
        chk(req, "abort_n", int'(abort_n), 1 - ab);
        chk(req, "common_sel", int'(common_sel), prot);
        chk(req, "phys_bank", int'(phys_bank), m_cur);
        chk(req, "mem_we_n", int'(mem_we_n),
            (valid != 0 && rw == 0 && ab == 0) ? 0 : 1);
        chk(req, "reg_rdata", int'(reg_rdata), exp_rdata(sel));
        @(posedge clk);
        if (ab != 0) begin
            m_faddr = addr; m_fbank = m_cur; m_frw = rw;
        end
        if (we != 0 && m_cur == m_priv) begin
            if (sel == 0) m_cur = wd & 255;
            if (sel == 1) m_priv = wd & 255;
        end
        #1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        for (int s = 0; s < 8; s++) cyc(0, 0, 1, 0, 0, s, 0, "R1");
        // R3 privileged bank reaches common area and I/O freely
        cyc('hC000, 9, 0, 1, 0, 0, 0, "R3");
        cyc('hD000, 9, 1, 1, 0, 0, 0, "R3");
        cyc('hFFFF, 0, 0, 1, 0, 0, 0, "R7");
        // R8 status writes ignored, then move to bank 3
        cyc(0, 0, 0, 0, 1, 4, 'h77, "R8");
        cyc(0, 0, 1, 0, 0, 4, 0, "R8");
        cyc(0, 0, 0, 0, 1, 0, 3, "R8");
        cyc(0, 0, 1, 0, 0, 0, 0, "R8");
        // R4 boundaries, R6 bank byte ignored
        cyc('hBFFF, 'h55, 0, 1, 0, 0, 0, "R4");
        cyc('h8000, 'hAA, 0, 1, 0, 0, 0, "R4");
        cyc('h4000, 'h01, 1, 1, 0, 0, 0, "R6");
        cyc('h1234, 'hFF, 0, 1, 0, 1, 0, "R6");
        // R2 / R11 protected write from user bank
        cyc('hC000, 0, 0, 1, 0, 2, 0, "R2");
        for (int s = 2; s < 6; s++) cyc(0, 0, 1, 0, 0, s, 0, "R10");
        // R5 invalid strobe on protected address
        cyc('hE123, 0, 0, 0, 0, 0, 0, "R5");
        // R2 read of I/O region
        cyc('hD010, 0, 1, 1, 0, 3, 0, "R2");
        cyc(0, 0, 1, 0, 0, 3, 0, "R10");
        cyc(0, 0, 1, 0, 0, 5, 0, "R10");
        // R9 refused register writes
        cyc('h0200, 0, 0, 0, 1, 0, 0, "R9");
        cyc('h0200, 0, 0, 0, 1, 1, 3, "R9");
        cyc(0, 0, 1, 0, 0, 0, 0, "R9");
        cyc(0, 0, 1, 0, 0, 1, 0, "R9");
        cyc(0, 0, 1, 0, 0, 2, 0, "R10");
        // R8 privileged bank moved away from the kernel
        do_reset();
        cyc(0, 0, 0, 0, 1, 1, 6, "R8");
        cyc('hC800, 0, 0, 1, 0, 1, 0, "R8");
        cyc(0, 0, 0, 0, 1, 0, 6, "R9");
        // R12 mixed traffic with occasional reset
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            if (i % 50 == 0) do_reset();
            cyc($urandom & 'hFFFF, $urandom & 255, r & 1, (r >> 1) & 1,
                ((r >> 2) & 7) == 0 ? 1 : 0, (r >> 5) & 7,
                (r >> 8) & 3, "R12");
        end
        finish_run();
    end
endmodule